// File: doc/BRIEF.md
# Floating-Point Control and Status Register Unit

This block holds the two architectural registers that steer and report on a CPU's floating-point arithmetic: a 16-bit control word and a 32-bit status word. Software-visible writes load either register, and both are read back combinationally. The control word's rounding and precision fields are decoded into one-hot mode lines for a downstream arithmetic datapath. These mode lines are registered and follow a control write by one cycle.

The status word's condition nibble has two update sources. A compare-result input reports one of four relations. A test-classification input reports the sign, NaN, infinity and zero flags of an operand. Either source rewrites only the condition nibble and leaves every other status bit as it was. A variant input selects between a full three-way precision decode and a reduced one-bit decode, which suits cores whose arithmetic supports only single and double precision.

Top module: `fpRegUnit`

## Requirements
- R1: After reset both read ports return zero, the rounding lines show nearest-even (roundOneHot = 0001) and the precision lines show extended (precOneHot = 001).
- R2: A control write stores data bits 15:0, and bits 31:16 of ctrlRdData always read zero.
- R3: One cycle after a control write, roundOneHot shows the code held in control bits 5:4 as a one-hot value, with bit k set for code k. Code 0 is nearest-even, 1 is toward zero, 2 is toward minus infinity and 3 is toward plus infinity.
- R4: When reducedMode is low, control bits 7:6 select the precision one cycle after the write. Code 00 gives extended (precOneHot bit 0), 01 gives single (bit 1) and 10 gives double (bit 2).
- R5: When reducedMode is low and control bits 7:6 are 11, the applied precision keeps its previous value. The code is still stored in the control register.
- R6: When reducedMode is high, a control write applies single precision if bit 6 is set and double precision otherwise, whatever the value of bit 7.
- R7: A compare update (cmpValid) writes the condition nibble at status bits 27:24, ordered N, Z, I, A from bit 27 down. cmpResult 00 (equal) sets only Z, 01 (less) sets only N, 11 (unordered) sets only A, and 10 (greater) clears all four.
- R8: A test update (tstValid) sets N whenever tstSign is high. It then sets exactly one of A (tstNan), I (tstInf) or Z (tstZero), taking them in that priority order, or none of them when no class flag is high.
- R9: A condition-code update changes only status bits 27:24 and leaves bits 31:28 and 23:0 unchanged.
- R10: A status write replaces all 32 bits. It takes precedence over a compare or test update in the same cycle.
- R11: When a compare update and a test update arrive in the same cycle, the compare update is the one applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Load the control register |
| ctrlWrData | input | 32 | Control write data |
| statWrEn | input | 1 | Load the whole status register |
| statWrData | input | 32 | Status write data |
| reducedMode | input | 1 | Select the one-bit precision decode |
| cmpValid | input | 1 | Compare result present |
| cmpResult | input | 2 | 00 equal, 01 less, 10 greater, 11 unordered |
| tstValid | input | 1 | Test classification present |
| tstSign | input | 1 | Operand is negative |
| tstNan | input | 1 | Operand is NaN |
| tstInf | input | 1 | Operand is infinite |
| tstZero | input | 1 | Operand is zero |
| ctrlRdData | output | 32 | Control register read, upper half zero |
| statRdData | output | 32 | Status register read |
| roundOneHot | output | 4 | Applied rounding direction, one-hot |
| precOneHot | output | 3 | Applied precision: bit 0 extended, 1 single, 2 double |

## Verification
Three status-word writers can coincide in one cycle: the full status write, the compare update and the test update. The bench provokes this by driving a status write together with a compare, and separately by driving a compare together with a test. The scoreboard expects the full-word value in the first case and the compare-derived nibble in the second, and in both cases it compares every status bit. Control writes are also issued in the same cycles as condition updates, to show that the two registers update independently.

// File: rtl/fpRegPkg.sv
package fpRegPkg;
  localparam int REG_W      = 32;
  localparam int CTRL_W     = 16;
  localparam int RND_LSB    = 4;
  localparam int RND_W      = 2;
  localparam int PREC_LSB   = 6;
  localparam int PREC_W     = 2;
  localparam int RND_MODES  = 1 << RND_W;
  localparam int PREC_MODES = 3;
  localparam int CC_LSB     = 24;
  localparam int CC_W       = 4;
  localparam int CC_MSB     = CC_LSB + CC_W - 1;

  localparam int CC_A = 0;
  localparam int CC_I = 1;
  localparam int CC_Z = 2;
  localparam int CC_N = 3;

  localparam int PREC_EXT = 0;
  localparam int PREC_SGL = 1;
  localparam int PREC_DBL = 2;

  typedef enum logic [1:0] {
    CMP_EQ = 2'b00,
    CMP_LT = 2'b01,
    CMP_GT = 2'b10,
    CMP_UN = 2'b11
  } cmpRel_e;

  typedef struct packed {
    logic                  ctrlLoad;
    logic                  precLoad;
    logic [PREC_MODES-1:0] precSel;
    logic                  statLoad;
    logic                  ccLoad;
    logic [CC_W-1:0]       ccNibble;
  } regStrobe_t;
endpackage

// File: rtl/fpRegCtrl.sv
module fpRegCtrl
  import fpRegPkg::*;
(
  input  logic              ctrlWrEn,
  input  logic [PREC_W-1:0] precCode,
  input  logic              reducedMode,
  input  logic              statWrEn,
  input  logic              cmpValid,
  input  logic [1:0]        cmpResult,
  input  logic              tstValid,
  input  logic              tstSign,
  input  logic              tstNan,
  input  logic              tstInf,
  input  logic              tstZero,
  output regStrobe_t        strobe
);
  logic [CC_W-1:0]       cmpNibble;
  logic [CC_W-1:0]       tstNibble;
  logic [PREC_MODES-1:0] fullSel;
  logic                  fullValid;

  always_comb begin
    cmpNibble = '0;
    unique case (cmpRel_e'(cmpResult))
      CMP_EQ:  cmpNibble[CC_Z] = 1'b1;
      CMP_LT:  cmpNibble[CC_N] = 1'b1;
      CMP_UN:  cmpNibble[CC_A] = 1'b1;
      default: cmpNibble = '0;
    endcase
  end

  always_comb begin
    tstNibble = '0;
    tstNibble[CC_N] = tstSign;
    if (tstNan)       tstNibble[CC_A] = 1'b1;
    else if (tstInf)  tstNibble[CC_I] = 1'b1;
    else if (tstZero) tstNibble[CC_Z] = 1'b1;
  end

  always_comb begin
    fullSel   = '0;
    fullValid = 1'b1;
    unique case (precCode)
      2'b00:   fullSel[PREC_EXT] = 1'b1;
      2'b01:   fullSel[PREC_SGL] = 1'b1;
      2'b10:   fullSel[PREC_DBL] = 1'b1;
      default: fullValid = 1'b0;
    endcase
  end

  always_comb begin
    strobe = '0;
    strobe.ctrlLoad = ctrlWrEn;
    strobe.statLoad = statWrEn;
    strobe.ccLoad   = !statWrEn && (cmpValid || tstValid);
    strobe.ccNibble = cmpValid ? cmpNibble : tstNibble;
    if (reducedMode) begin
      strobe.precLoad = ctrlWrEn;
      strobe.precSel[PREC_SGL] = precCode[0];
      strobe.precSel[PREC_DBL] = !precCode[0];
    end else begin
      strobe.precLoad = ctrlWrEn && fullValid;
      strobe.precSel  = fullSel;
    end
  end
endmodule

// File: rtl/fpRegData.sv
module fpRegData
  import fpRegPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  regStrobe_t            strobe,
  input  logic [CTRL_W-1:0]     ctrlWrData,
  input  logic [REG_W-1:0]      statWrData,
  output logic [REG_W-1:0]      ctrlRdData,
  output logic [REG_W-1:0]      statRdData,
  output logic [RND_MODES-1:0]  roundOneHot,
  output logic [PREC_MODES-1:0] precOneHot
);
  logic [CTRL_W-1:0]     ctrlReg;
  logic [REG_W-1:0]      statReg;
  logic [PREC_MODES-1:0] precReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      precReg <= PREC_MODES'(1) << PREC_EXT;
    end else begin
      if (strobe.ctrlLoad) ctrlReg <= ctrlWrData;
      if (strobe.precLoad) precReg <= strobe.precSel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statReg <= '0;
    end else if (strobe.statLoad) begin
      statReg <= statWrData;
    end else if (strobe.ccLoad) begin
      statReg[CC_MSB:CC_LSB] <= strobe.ccNibble;
    end
  end

  logic [RND_W-1:0] rndCode;
  assign rndCode = ctrlReg[RND_LSB +: RND_W];

  for (genvar g = 0; g < RND_MODES; g++) begin : gRound
    assign roundOneHot[g] = (rndCode == RND_W'(g));
  end

  assign ctrlRdData = {{(REG_W-CTRL_W){1'b0}}, ctrlReg};
  assign statRdData = statReg;
  assign precOneHot = precReg;
endmodule

// File: rtl/fpRegUnit.sv
module fpRegUnit
  import fpRegPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctrlWrEn,
  input  logic [31:0] ctrlWrData,
  input  logic        statWrEn,
  input  logic [31:0] statWrData,
  input  logic        reducedMode,
  input  logic        cmpValid,
  input  logic [1:0]  cmpResult,
  input  logic        tstValid,
  input  logic        tstSign,
  input  logic        tstNan,
  input  logic        tstInf,
  input  logic        tstZero,
  output logic [31:0] ctrlRdData,
  output logic [31:0] statRdData,
  output logic [3:0]  roundOneHot,
  output logic [2:0]  precOneHot
);
  regStrobe_t strobe;
  wire unusedUpperBits = ^ctrlWrData[REG_W-1:CTRL_W];

  fpRegCtrl uCtrl (
    .ctrlWrEn    (ctrlWrEn),
    .precCode    (ctrlWrData[PREC_LSB +: PREC_W]),
    .reducedMode (reducedMode),
    .statWrEn    (statWrEn),
    .cmpValid    (cmpValid),
    .cmpResult   (cmpResult),
    .tstValid    (tstValid),
    .tstSign     (tstSign),
    .tstNan      (tstNan),
    .tstInf      (tstInf),
    .tstZero     (tstZero),
    .strobe      (strobe)
  );

  fpRegData uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .ctrlWrData  (ctrlWrData[CTRL_W-1:0]),
    .statWrData  (statWrData),
    .ctrlRdData  (ctrlRdData),
    .statRdData  (statRdData),
    .roundOneHot (roundOneHot),
    .precOneHot  (precOneHot)
  );
endmodule

// File: rtl/fpRegChecker.sv
module fpRegChecker (
  input logic        clk,
  input logic        rstN,
  input logic        ctrlWrEn,
  input logic [31:0] ctrlWrData,
  input logic        statWrEn,
  input logic [31:0] statWrData,
  input logic        reducedMode,
  input logic        cmpValid,
  input logic [1:0]  cmpResult,
  input logic        tstValid,
  input logic [31:0] ctrlRdData,
  input logic [31:0] statRdData,
  input logic [3:0]  roundOneHot,
  input logic [2:0]  precOneHot
);
  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRdData[31:16] == 16'h0);

  p_round_code_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrEn |=> roundOneHot == (4'b0001 << $past(ctrlWrData[5:4])));

  p_prec_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $countones(precOneHot) == 1);

  p_prec_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && !reducedMode && ctrlWrData[7:6] == 2'b11) |=> $stable(precOneHot));

  p_reduced_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && reducedMode) |=>
      precOneHot == ($past(ctrlWrData[6]) ? 3'b010 : 3'b100));

  p_cmp_eq_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmpValid && !statWrEn && cmpResult == 2'b00) |=> statRdData[27:24] == 4'b0100);

  p_cc_keep_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((cmpValid || tstValid) && !statWrEn) |=>
      (statRdData[23:0] == $past(statRdData[23:0]) &&
       statRdData[31:28] == $past(statRdData[31:28])));

  p_stat_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    statWrEn |=> statRdData == $past(statWrData));
endmodule

bind fpRegUnit fpRegChecker chk (.*);

// File: tb/fpRegUnit_test.sv
module fpRegUnit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWrEn = 1'b0;
  logic [31:0] ctrlWrData = '0;
  logic        statWrEn = 1'b0;
  logic [31:0] statWrData = '0;
  logic        reducedMode = 1'b0;
  logic        cmpValid = 1'b0;
  logic [1:0]  cmpResult = '0;
  logic        tstValid = 1'b0;
  logic        tstSign = 1'b0;
  logic        tstNan = 1'b0;
  logic        tstInf = 1'b0;
  logic        tstZero = 1'b0;
  logic [31:0] ctrlRdData;
  logic [31:0] statRdData;
  logic [3:0]  roundOneHot;
  logic [2:0]  precOneHot;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    string       tag;
    logic [31:0] ctrl;
    logic [31:0] stat;
    logic [3:0]  rnd;
    logic [2:0]  prec;
  } expItem_t;

  expItem_t scoreQ[$];

  logic [15:0] mCtrl = '0;
  logic [31:0] mStat = '0;
  logic [2:0]  mPrec = 3'b001;

  always #10 clk = ~clk;

  fpRegUnit uut (.*);

  task automatic cmpField(string tag, string name, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, name, act, exp);
    end
  endtask

  // monitor: samples 5 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (scoreQ.size() > 0) begin
        expItem_t it;
        it = scoreQ.pop_front();
        cmpField(it.tag, "ctrl",  ctrlRdData, it.ctrl);
        cmpField(it.tag, "stat",  statRdData, it.stat);
        cmpField(it.tag, "round", 32'(roundOneHot), 32'(it.rnd));
        cmpField(it.tag, "prec",  32'(precOneHot), 32'(it.prec));
      end
    end
  end

  task automatic pushExp(string tag);
    expItem_t it;
    it.tag  = tag;
    it.ctrl = {16'h0, mCtrl};
    it.stat = mStat;
    it.rnd  = 4'b0001 << mCtrl[5:4];
    it.prec = mPrec;
    scoreQ.push_back(it);
  endtask

  // driver: applies one cycle of stimulus at a falling edge and predicts the result
  task automatic drive(string tag,
                       bit cw, logic [31:0] cd, bit red,
                       bit sw, logic [31:0] sd,
                       bit cv, logic [1:0] cr,
                       bit tv, logic [3:0] tf);
    logic [3:0] cc;
    @(negedge clk);
    ctrlWrEn = cw; ctrlWrData = cd; reducedMode = red;
    statWrEn = sw; statWrData = sd;
    cmpValid = cv; cmpResult = cr;
    tstValid = tv; {tstSign, tstNan, tstInf, tstZero} = tf;
    if (cw) begin
      mCtrl = cd[15:0];
      if (red) mPrec = cd[6] ? 3'b010 : 3'b100;
      else begin
        case (cd[7:6])
          2'b00: mPrec = 3'b001;
          2'b01: mPrec = 3'b010;
          2'b10: mPrec = 3'b100;
          default: ;
        endcase
      end
    end
    if (sw) mStat = sd;
    else if (cv) begin
      case (cr)
        2'b00: cc = 4'b0100;
        2'b01: cc = 4'b1000;
        2'b11: cc = 4'b0001;
        default: cc = 4'b0000;
      endcase
      mStat[27:24] = cc;
    end else if (tv) begin
      cc = {tf[3], 3'b000};
      if (tf[2]) cc[0] = 1'b1;
      else if (tf[1]) cc[1] = 1'b1;
      else if (tf[0]) cc[2] = 1'b1;
      mStat[27:24] = cc;
    end
    pushExp(tag);
  endtask

  task automatic idle(string tag);
    drive(tag, 0, '0, 0, 0, '0, 0, 2'b00, 0, 4'h0);
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    pushExp("R1");
    @(negedge clk);
    rstN = 1'b1;
    idle("R1");

    // R2: upper half dropped
    drive("R2", 1, 32'hFFFF_0000, 0, 0, '0, 0, 2'b00, 0, 4'h0);
    drive("R2", 1, 32'hA5A5_1200, 0, 0, '0, 0, 2'b00, 0, 4'h0);
    // R3: each rounding code, with R4 precision variations
    drive("R3", 1, 32'h0000_0000, 0, 0, '0, 0, 2'b00, 0, 4'h0);
    drive("R3", 1, 32'h0000_0050, 0, 0, '0, 0, 2'b00, 0, 4'h0);
    drive("R3", 1, 32'h0000_00A0, 0, 0, '0, 0, 2'b00, 0, 4'h0);
    drive("R3", 1, 32'h0000_FF30, 0, 0, '0, 0, 2'b00, 0, 4'h0);
    // R4: full decode
    drive("R4", 1, 32'h0000_0000, 0, 0, '0, 0, 2'b00, 0, 4'h0);
    drive("R4", 1, 32'h0000_0040, 0, 0, '0, 0, 2'b00, 0, 4'h0);
    drive("R4", 1, 32'h0000_0080, 0, 0, '0, 0, 2'b00, 0, 4'h0);
    // R5: undefined code keeps double, then keeps single
    drive("R5", 1, 32'h0000_00D0, 0, 0, '0, 0, 2'b00, 0, 4'h0);
    drive("R5", 1, 32'h0000_0040, 0, 0, '0, 0, 2'b00, 0, 4'h0);
    drive("R5", 1, 32'h0000_01E0, 0, 0, '0, 0, 2'b00, 0, 4'h0);
    // R6: reduced decode ignores bit 7
    drive("R6", 1, 32'h0000_0080, 1, 0, '0, 0, 2'b00, 0, 4'h0);
    drive("R6", 1, 32'h0000_00C0, 1, 0, '0, 0, 2'b00, 0, 4'h0);
    drive("R6", 1, 32'h0000_0000, 1, 0, '0, 0, 2'b00, 0, 4'h0);
    drive("R6", 1, 32'h0000_0040, 1, 0, '0, 0, 2'b00, 0, 4'h0);
    // R10: full status write
    drive("R10", 0, '0, 0, 1, 32'hF3A5_C3E1, 0, 2'b00, 0, 4'h0);
    // R7 and R9: compare relations keep other bits
    drive("R7", 0, '0, 0, 0, '0, 1, 2'b00, 0, 4'h0);
    drive("R7", 0, '0, 0, 0, '0, 1, 2'b01, 0, 4'h0);
    drive("R9", 0, '0, 0, 0, '0, 1, 2'b11, 0, 4'h0);
    drive("R9", 1, 32'h0000_0010, 0, 0, '0, 1, 2'b10, 0, 4'h0);
    // R8: test classifications {sign, nan, inf, zero}
    drive("R8", 0, '0, 0, 0, '0, 0, 2'b00, 1, 4'b0000);
    drive("R8", 0, '0, 0, 0, '0, 0, 2'b00, 1, 4'b1000);
    drive("R8", 0, '0, 0, 0, '0, 0, 2'b00, 1, 4'b1001);
    drive("R8", 0, '0, 0, 0, '0, 0, 2'b00, 1, 4'b0010);
    drive("R8", 0, '0, 0, 0, '0, 0, 2'b00, 1, 4'b1110);
    drive("R8", 0, '0, 0, 0, '0, 0, 2'b00, 1, 4'b0101);
    drive("R8", 0, '0, 0, 0, '0, 0, 2'b00, 1, 4'b0011);
    // R11: compare wins over test
    drive("R11", 0, '0, 0, 0, '0, 1, 2'b00, 1, 4'b1010);
    drive("R11", 0, '0, 0, 0, '0, 1, 2'b10, 1, 4'b0100);
    // R10: status write wins over compare and test
    drive("R10", 0, '0, 0, 1, 32'h0F00_1234, 1, 2'b01, 0, 4'h0);
    drive("R10", 0, '0, 0, 1, 32'h5000_00AA, 0, 2'b00, 1, 4'b1100);
    drive("R9", 0, '0, 0, 0, '0, 1, 2'b01, 0, 4'h0);
    idle("R9");
    idle("R9");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    finishRun();
  end
endmodule